// File: doc/BRIEF.md
# Pulse Accumulator with Gated Timing Mode

This timer peripheral watches one external input pin. It either counts the transitions on that pin or measures how long the pin stays at one level. In event mode, each active transition of the synchronized input adds one to a 16-bit count register. In gated mode, the active transition opens a gate. While the gate is open, a divide-by-64 prescaler fed by the bus clock advances the count. The opposite transition closes the gate. The count then holds the gate width in units of 64 bus cycles.

Two sticky flags report progress. The edge flag marks an event, or the end of a gated measurement. The overflow flag marks a wrap of the count. Each flag has its own interrupt enable and its own request output. Software works through a small word-wide register port with three locations: control, count and flags. Flags are cleared by writing 1 to them. A write to the count register presets the counter.

Top module: `pulse_acc`

## Requirements
- R1: After reset, the control, count and flag registers read 0 and both interrupt outputs are 0. While the enable bit (control bit 0) is 0, input transitions leave the count and the edge flag unchanged.
- R2: The input pin passes through a two-stage synchronizer. Each transition of the pin produces exactly one active or opposite edge event, one clock cycle long. The count changes on the third rising clock edge after the pin changes.
- R3: Control bit 2 selects the polarity. When it is 0, the rising transition is the active edge. When it is 1, the falling transition is the active edge.
- R4: In event mode (control bit 1 = 0), each active edge adds one to the count and sets the edge flag (flags bit 0). Opposite edges have no effect.
- R5: In gated mode (control bit 1 = 1), the active edge opens the gate. The count then grows by one for every 64 clock cycles the gate stays open. A gate held open for L cycles adds floor(L/64).
- R6: In gated mode, opening the gate does not set the edge flag. The closing opposite edge does set it.
- R7: An increment from 0xFFFF to 0x0000 sets the overflow flag (flags bit 1).
- R8: The prescaler restarts from zero each time the gate opens. It holds while the gate is closed. Back-to-back gated measurements therefore do not share partial prescaler periods.
- R9: Writing 1 to a flag bit at address 2 clears that flag. Writing 0 leaves it. If a set event and a clear happen in the same cycle, the flag ends up set.
- R10: irq_edge is high exactly when the edge flag and control bit 3 are both 1. irq_ovf is high exactly when the overflow flag and control bit 4 are both 1.
- R11: A write to address 1 loads the count. If the write and an increment happen in the same cycle, the written value wins.
- R12: The register map reads as follows: address 0 gives the control bits in [4:0], address 1 gives the count, address 2 gives the flags in [1:0]. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous external input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 count, 2 flags) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_edge | output | 1 | Edge interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions assume three things about the inputs. First, the register port presents one well-formed write per cycle. Second, the pin holds each level for at least one clock after synchronization, so that every transition shows up as a single clean edge event. Third, mode and polarity do not change while a gated measurement is in progress. The stimulus respects all three. It reprograms the control register only while the pin sits at its idle level. It spaces random pin transitions by several cycles. It draws random gate widths and event counts from $urandom with a fixed seed. Directed cases align a count write, and then a flag clear, with the exact cycle of an increment. Other directed cases preset the count just below the wrap in both modes.

// File: rtl/pacc_pkg.sv
// Package: shared types and register addresses for the pulse accumulator.
// Assumes a word-wide register port with a two-bit address.
package pacc_pkg;

    // Control register layout, LSB first: enable, gated, falling, edge IE, ovf IE
    typedef struct packed {
        logic ie_ovf;
        logic ie_edge;
        logic falling;
        logic gated;
        logic en;
    } ctrl_t;

    localparam int CTRL_BITS = 5;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_FLAGS = 2'd2;

endpackage

// File: rtl/pacc_sync_edge.sv
// Module: input synchronizer and edge classifier.
// Takes an asynchronous pin through STAGES flops, then produces single-cycle
// active and opposite edge pulses according to the polarity select.
// Assumes STAGES >= 2.
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic falling,
    output logic act_edge,
    output logic opp_edge
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;
    logic              rise;
    logic              fall;

    // Shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    assign lvl = sync_q[STAGES-1];

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Classify transitions by the chosen polarity
    always_comb begin
        rise     = lvl & ~prev_q;
        fall     = ~lvl & prev_q;
        act_edge = falling ? fall : rise;
        opp_edge = falling ? rise : fall;
    end

    assert_single_cycle_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> !act_edge);
    assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_edge && opp_edge));

endmodule

// File: rtl/pacc_prescale.sv
// Module: gated prescaler.
// Counts clock cycles while the gate is open and pulses a tick every DIV
// cycles. Restarts from zero on request and holds while the gate is closed.
// Assumes DIV >= 2.
module pacc_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic gate_open,
    output logic tick
);

    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    // Advance, wrap or restart the prescaler phase
    always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (restart)   pre_q <= '0;
        else if (gate_open) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end

    assign tick = gate_open && (pre_q == LAST);

    assert_restart_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));
    assert_hold_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !restart) |=> $stable(pre_q));

endmodule

// File: rtl/pacc_core.sv
// Module: counting core.
// Holds the gate state and the count. It decides when to increment in each
// mode and reports flag set events. Assumes the edge inputs are single-cycle
// pulses.
module pacc_core #(
    parameter int CNT_W = 16,
    parameter int DIV   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gated,
    input  logic             act_edge,
    input  logic             opp_edge,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count,
    output logic             edge_set,
    output logic             ovf_set
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic gate_q;
    logic restart;
    logic tick;
    logic inc;

    // Open the gate on an active edge and close it on the opposite edge
    always_ff @(posedge clk) begin
        if (!rst_n)                    gate_q <= 1'b0;
        else if (!en || !gated)        gate_q <= 1'b0;
        else if (act_edge && !gate_q)  gate_q <= 1'b1;
        else if (opp_edge && gate_q)   gate_q <= 1'b0;
    end

    assign restart = en && gated && act_edge && !gate_q;

    pacc_prescale #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .gate_open (gate_q),
        .tick      (tick)
    );

    // Decide on increments and flag events for the current mode
    always_comb begin
        inc      = en && (gated ? (gate_q && tick) : act_edge);
        edge_set = en && (gated ? (opp_edge && gate_q) : act_edge);
        ovf_set  = inc && !cnt_wr && (count == CNT_MAX);
    end

    // Load the count on a write, otherwise increment it
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= cnt_wdata;
        else if (inc)    count <= count + 1'b1;
    end

    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(count));
    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> (count == '0));
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(cnt_wdata)));
    assert_gate_open_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && act_edge && !gate_q) |-> !edge_set);

endmodule

// File: rtl/pulse_acc.sv
// Module: pulse accumulator top.
// Provides the register port (control, count, flags), the sticky flags with
// write-1-to-clear and the two interrupt requests. Assumes CNT_W >= 5.
module pulse_acc #(
    parameter int CNT_W       = 16,
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_edge,
    output logic             irq_ovf
);
    import pacc_pkg::*;

    ctrl_t            ctrl_q;
    logic             flag_edge_q;
    logic             flag_ovf_q;
    logic             act_edge;
    logic             opp_edge;
    logic             cnt_wr;
    logic             flag_wr;
    logic [CNT_W-1:0] count;
    logic             edge_set;
    logic             ovf_set;

    assign cnt_wr  = reg_wr && (reg_addr == ADDR_COUNT);
    assign flag_wr = reg_wr && (reg_addr == ADDR_FLAGS);

    // Capture control writes
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctrl_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
    end

    pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pin_in),
        .falling  (ctrl_q.falling),
        .act_edge (act_edge),
        .opp_edge (opp_edge)
    );

    pacc_core #(.CNT_W(CNT_W), .DIV(DIV)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q.en),
        .gated     (ctrl_q.gated),
        .act_edge  (act_edge),
        .opp_edge  (opp_edge),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (reg_wdata),
        .count     (count),
        .edge_set  (edge_set),
        .ovf_set   (ovf_set)
    );

    // Sticky flags: a set event outranks a write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_edge_q <= 1'b0;
            flag_ovf_q  <= 1'b0;
        end else begin
            flag_edge_q <= (flag_edge_q & ~(flag_wr & reg_wdata[0])) | edge_set;
            flag_ovf_q  <= (flag_ovf_q  & ~(flag_wr & reg_wdata[1])) | ovf_set;
        end
    end

    // Drive the interrupt requests from flags and enables
    always_comb begin
        irq_edge = flag_edge_q & ctrl_q.ie_edge;
        irq_ovf  = flag_ovf_q  & ctrl_q.ie_ovf;
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:  reg_rdata[CTRL_BITS-1:0] = ctrl_q;
            ADDR_COUNT: reg_rdata = count;
            ADDR_FLAGS: reg_rdata[1:0] = {flag_ovf_q, flag_edge_q};
            default:    reg_rdata = '0;
        endcase
    end

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_set |=> flag_edge_q);
    assert_ovf_set_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag_ovf_q);
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && reg_wdata[0] && !edge_set) |=> !flag_edge_q);
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge || irq_ovf) |-> (ctrl_q.ie_edge || ctrl_q.ie_ovf));

endmodule

// File: tb/sim_pulse_acc.sv
module sim_pulse_acc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq_edge;
    logic        irq_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [15:0] C_EN = 16'h0001, C_GATED = 16'h0002, C_FALL = 16'h0004,
                            C_IEE = 16'h0008, C_IEO = 16'h0010;

    pulse_acc u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_edge(irq_edge), .irq_ovf(irq_ovf)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] gated_gain(input int len);
        return 16'(len / 64);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic toggle();
        @(negedge clk);
        pin_in = ~pin_in;
        repeat (5) @(posedge clk);
    endtask

    // Hold the pin at its active level for len cycles, then return it to idle
    task automatic gate_pulse(input logic act_lvl, input int len);
        @(negedge clk);
        pin_in = act_lvl;
        repeat (len) @(posedge clk);
        @(negedge clk);
        pin_in = ~act_lvl;
        repeat (6) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp_cnt;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 R12: reset state
        rd(2'd0, v); chk(v == 16'h0, "R1 ctrl reset", v, 16'h0);
        rd(2'd1, v); chk(v == 16'h0, "R1 count reset", v, 16'h0);
        rd(2'd2, v); chk(v == 16'h0, "R1 flags reset", v, 16'h0);
        chk(!irq_edge && !irq_ovf, "R1 irq reset", {14'd0, irq_ovf, irq_edge}, 16'h0);

        // R12: control readback
        wr(2'd0, 16'hFFFF); rd(2'd0, v);
        chk(v == 16'h001F, "R12 ctrl readback", v, 16'h001F);
        wr(2'd0, 16'h0000);

        // R4: random event counts on rising edges
        for (int t = 0; t < 4; t++) begin
            int n;
            n = 2 + int'($urandom % 9);
            wr(2'd1, 16'h0); wr(2'd2, 16'h3);
            wr(2'd0, C_EN);
            for (int k = 0; k < n; k++) begin toggle(); toggle(); end
            rd(2'd1, v); chk(v == 16'(n), "R4 event count", v, 16'(n));
            rd(2'd2, v); chk(v[0] == 1'b1, "R4 edge flag", v, 16'h1);
        end

        // R2: one transition gives one count, at the third edge
        wr(2'd1, 16'h0);
        @(negedge clk) pin_in = 1'b1;
        repeat (2) @(posedge clk);
        rd(2'd1, v); chk(v == 16'h0, "R2 not yet counted", v, 16'h0);
        repeat (4) @(posedge clk);
        rd(2'd1, v); chk(v == 16'h1, "R2 single count", v, 16'h1);
        toggle();

        // R1: disabled ignores edges
        wr(2'd0, 16'h0); wr(2'd2, 16'h3); wr(2'd1, 16'h0042);
        for (int k = 0; k < 3; k++) begin toggle(); toggle(); end
        rd(2'd1, v); chk(v == 16'h0042, "R1 disabled count", v, 16'h0042);
        rd(2'd2, v); chk(v == 16'h0, "R1 disabled flag", v, 16'h0);

        // R3: falling polarity
        pin_in = 1'b1; repeat (5) @(posedge clk);
        wr(2'd0, C_EN | C_FALL); wr(2'd1, 16'h0);
        toggle(); // falling
        rd(2'd1, v); chk(v == 16'h1, "R3 falling counted", v, 16'h1);
        toggle(); // rising
        rd(2'd1, v); chk(v == 16'h1, "R3 rising ignored", v, 16'h1);
        wr(2'd0, 16'h0); pin_in = 1'b0; repeat (5) @(posedge clk);

        // R9: write-1-clear, write-0 keeps
        wr(2'd0, C_EN); wr(2'd2, 16'h3);
        toggle(); toggle();
        wr(2'd2, 16'h0); rd(2'd2, v); chk(v[0] == 1'b1, "R9 write0 keeps", v, 16'h1);
        wr(2'd2, 16'h1); rd(2'd2, v); chk(v[0] == 1'b0, "R9 write1 clears", v, 16'h0);

        // R10: edge interrupt gating
        wr(2'd0, C_EN | C_IEE);
        toggle(); toggle();
        #1 chk(irq_edge == 1'b1, "R10 irq_edge on", {15'd0, irq_edge}, 16'h1);
        wr(2'd0, C_EN);
        #1 chk(irq_edge == 1'b0, "R10 irq_edge masked", {15'd0, irq_edge}, 16'h0);

        // R7 R10: event overflow
        wr(2'd0, C_EN | C_IEO); wr(2'd2, 16'h3); wr(2'd1, 16'hFFFF);
        toggle(); toggle();
        rd(2'd1, v); chk(v == 16'h0, "R7 event wrap", v, 16'h0);
        rd(2'd2, v); chk(v[1] == 1'b1, "R7 ovf flag", v, 16'h2);
        chk(irq_ovf == 1'b1, "R10 irq_ovf on", {15'd0, irq_ovf}, 16'h1);

        // R11: count write coincides with an increment
        wr(2'd0, C_EN); wr(2'd1, 16'h0); wr(2'd2, 16'h3);
        @(negedge clk) pin_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h1234; end
        @(negedge clk) reg_wr = 1'b0;
        rd(2'd1, v); chk(v == 16'h1234, "R11 load wins", v, 16'h1234);
        rd(2'd2, v); chk(v[0] == 1'b1, "R11 edge still flagged", v, 16'h1);

        // R9: flag clear coincides with a set event
        wr(2'd2, 16'h3);
        @(negedge clk) pin_in = 1'b0;
        @(negedge clk) pin_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) begin reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h1; end
        @(negedge clk) reg_wr = 1'b0;
        rd(2'd2, v); chk(v[0] == 1'b1, "R9 set wins", v, 16'h1);
        toggle(); wr(2'd0, 16'h0);

        // R5 R6: random gate widths
        wr(2'd0, C_EN | C_GATED);
        for (int t = 0; t < 5; t++) begin
            int len;
            len = 40 + int'($urandom % 360);
            wr(2'd1, 16'h0); wr(2'd2, 16'h3);
            @(negedge clk) pin_in = 1'b1;
            repeat (len / 2) @(posedge clk);
            rd(2'd2, v); chk(v[0] == 1'b0, "R6 open no flag", v, 16'h0);
            repeat (len - len / 2 - 1) @(posedge clk);
            @(negedge clk) pin_in = 1'b0;
            repeat (6) @(posedge clk);
            exp_cnt = gated_gain(len);
            rd(2'd1, v); chk(v == exp_cnt, "R5 gated width", v, exp_cnt);
            rd(2'd2, v); chk(v[0] == 1'b1, "R6 close sets flag", v, 16'h1);
        end

        // R8: two gates of 100 cycles each, prescaler restarts
        wr(2'd1, 16'h0);
        gate_pulse(1'b1, 100);
        gate_pulse(1'b1, 100);
        exp_cnt = gated_gain(100) + gated_gain(100);
        rd(2'd1, v); chk(v == exp_cnt, "R8 prescaler restart", v, exp_cnt);

        // R3 R5: gated with falling polarity
        wr(2'd0, 16'h0); pin_in = 1'b1; repeat (5) @(posedge clk);
        wr(2'd0, C_EN | C_GATED | C_FALL); wr(2'd1, 16'h0);
        gate_pulse(1'b0, 200);
        exp_cnt = gated_gain(200);
        rd(2'd1, v); chk(v == exp_cnt, "R3 gated low pulse", v, exp_cnt);

        // R7: gated overflow
        wr(2'd2, 16'h3); wr(2'd1, 16'hFFFE);
        gate_pulse(1'b0, 130);
        rd(2'd1, v); chk(v == 16'h0, "R7 gated wrap", v, 16'h0);
        rd(2'd2, v); chk(v[1] == 1'b1, "R7 gated ovf flag", v, 16'h2);

        finish_run();
    end

endmodule